// File: doc/BRIEF.md
# Bank-Window Address Mapper with Readback

This block widens the address reach of an 8-bit processor with a 16-bit address bus. The upper two address bits split the processor's space into four windows of 16 KiB. Each window has its own 8-bit bank number in a small register file. When remapping is switched on, the bank number of the current window replaces the two window bits on the physical address, giving a 22-bit physical address. The low 14 address bits always pass through unchanged. When remapping is switched off, the physical address is the processor address with zeros in the upper bits.

The processor loads bank numbers by writing to a four-byte I/O region. The low two address bits pick the entry. The same entries can be read back from that region, so software needs no copy of the bank state in RAM. A second four-byte range sits in RAM and acts as an alias of the map. A write there lands in both RAM and the matching entry. A read there is left to RAM alone. Entries capture data when the bus phase clock falls. The readback driver is enabled only while the phase clock is high.

Top module: `bmap_unit`

## Requirements
- R1: After reset, entry n holds the value n (identity mapping). This shows on the physical address and on readback.
- R2: With `remap_on` high, `pa[21:14]` equals the entry selected by `addr[15:14]`, and `pa[13:0]` equals `addr[13:0]`.
- R3: With `remap_on` low, `pa` equals `addr` zero-extended to 22 bits.
- R4: A write cycle (`rw`=0) to `IO_BASE`..`IO_BASE+3` loads `dbus_in` into entry `addr[1:0]`. The data is taken at the first clock edge that samples `phi2` low after it was sampled high.
- R5: A write cycle to `ALIAS_BASE`..`ALIAS_BASE+3` loads entry `addr[1:0]` in the same way as R4.
- R6: A read cycle (`rw`=1) to the I/O region drives `dbus_oe` high while `phi2` is high, with `dbus_out` equal to entry `addr[1:0]`.
- R7: `dbus_oe` is low whenever `phi2` is low.
- R8: A read cycle to the alias range leaves `dbus_oe` low.
- R9: Write cycles to any other address, and all read cycles, leave every entry unchanged.
- R10: A newly written entry appears on `pa` within one clock after the capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| phi2 | input | 1 | Bus phase clock; high is the data phase |
| rw | input | 1 | 1 = processor read, 0 = processor write |
| addr | input | 16 | Processor address |
| dbus_in | input | 8 | Data bus from the processor |
| remap_on | input | 1 | Enables window translation |
| pa | output | 22 | Physical address toward memory |
| dbus_out | output | 8 | Readback data, zero when not driving |
| dbus_oe | output | 1 | Data bus output enable |

## Verification
The bench goes after the phase edges. A design that took writes on the rising edge of `phi2`, or kept driving the bus after `phi2` fell, is caught by the capture-cycle and released-enable checks. Reads of the alias range are checked to stay off the bus; a design that decoded the alias like the I/O region would fight RAM for the bus. Writes just outside both regions, and read cycles, are checked to leave the map intact; a loose decode would corrupt a bank. Toggling `remap_on` shows whether the untranslated path really zero-extends the address.

// File: rtl/bmap_pkg.sv
package bmap_pkg;
  typedef enum logic [1:0] {
    CYC_NONE  = 2'd0,
    CYC_IO    = 2'd1,
    CYC_ALIAS = 2'd2
  } cyc_kind_e;
endpackage

// File: rtl/bmap_decode.sv
module bmap_decode
  import bmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W = 2,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'hFE00,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 16'h0200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             phi2,
  input  logic             rw,
  input  logic [ADDR_W-1:0] addr,
  output cyc_kind_e        kind,
  output logic             wr_stb,
  output logic             rd_oe,
  output logic [IDX_W-1:0] idx
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic phi2_q;
  logic [TAG_W-1:0] tag;

  always_ff @(posedge clk) begin
    if (rst) phi2_q <= 1'b0;
    else     phi2_q <= phi2;
  end

  assign tag = addr[ADDR_W-1:IDX_W];
  assign idx = addr[IDX_W-1:0];

  always_comb begin
    if (tag == IO_BASE[ADDR_W-1:IDX_W])         kind = CYC_IO;
    else if (tag == ALIAS_BASE[ADDR_W-1:IDX_W]) kind = CYC_ALIAS;
    else                                        kind = CYC_NONE;
  end

  // capture on the phase clock's falling edge, write cycles only
  assign wr_stb = phi2_q & ~phi2 & ~rw & (kind != CYC_NONE);
  // drive only in the data phase of a read of the I/O region
  assign rd_oe  = phi2 & rw & (kind == CYC_IO);
endmodule

// File: rtl/bmap_regfile.sv
module bmap_regfile #(
  parameter int DATA_W = 8,
  parameter int IDX_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_stb,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [(1<<IDX_W)-1:0][DATA_W-1:0] table_q
);
  localparam int ENTRIES = 1 << IDX_W;

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (rst)
        table_q[i] <= DATA_W'(i);
      else if (wr_stb && wr_idx == IDX_W'(i))
        table_q[i] <= wr_data;
    end
  end
endmodule

// File: rtl/bmap_lookup.sv
module bmap_lookup #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W = 2,
  localparam int OFS_W = ADDR_W - IDX_W,
  localparam int PA_W = DATA_W + OFS_W
) (
  input  logic [(1<<IDX_W)-1:0][DATA_W-1:0] table_q,
  input  logic [ADDR_W-1:0] addr,
  input  logic remap_on,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [PA_W-1:0] pa,
  output logic [DATA_W-1:0] rb_data
);
  logic [IDX_W-1:0] win;

  assign win = addr[ADDR_W-1 -: IDX_W];

  // translation port: read-only view of the table
  assign pa = remap_on ? {table_q[win], addr[OFS_W-1:0]} : PA_W'(addr);
  // processor readback port
  assign rb_data = table_q[rb_idx];
endmodule

// File: rtl/bmap_unit.sv
module bmap_unit
  import bmap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W = 2,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'hFE00,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 16'h0200,
  localparam int PA_W = DATA_W + ADDR_W - IDX_W
) (
  input  logic clk,
  input  logic rst,
  input  logic phi2,
  input  logic rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dbus_in,
  input  logic remap_on,
  output logic [PA_W-1:0] pa,
  output logic [DATA_W-1:0] dbus_out,
  output logic dbus_oe
);
  cyc_kind_e kind;
  logic wr_stb;
  logic rd_oe;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] rb_data;
  logic [(1<<IDX_W)-1:0][DATA_W-1:0] table_q;

  bmap_decode #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .IO_BASE(IO_BASE), .ALIAS_BASE(ALIAS_BASE)
  ) u_dec (
    .clk(clk), .rst(rst), .phi2(phi2), .rw(rw), .addr(addr),
    .kind(kind), .wr_stb(wr_stb), .rd_oe(rd_oe), .idx(idx)
  );

  bmap_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rf (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_idx(idx),
    .wr_data(dbus_in), .table_q(table_q)
  );

  bmap_lookup #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_lk (
    .table_q(table_q), .addr(addr), .remap_on(remap_on), .rb_idx(idx),
    .pa(pa), .rb_data(rb_data)
  );

  assign dbus_oe  = rd_oe;
  assign dbus_out = rd_oe ? rb_data : '0;
endmodule

// File: rtl/bmap_unit_chk.sv
module bmap_unit_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int IDX_W = 2,
  parameter logic [ADDR_W-1:0] IO_BASE = 16'hFE00,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 16'h0200,
  localparam int PA_W = DATA_W + ADDR_W - IDX_W
) (
  input logic clk,
  input logic rst,
  input logic phi2,
  input logic rw,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dbus_in,
  input logic remap_on,
  input logic [PA_W-1:0] pa,
  input logic [DATA_W-1:0] dbus_out,
  input logic dbus_oe
);
  localparam int OFS_W = ADDR_W - IDX_W;

  logic ph_d;
  logic in_alias;
  logic in_io;
  logic cap;

  always_ff @(posedge clk) begin
    if (rst) ph_d <= 1'b0;
    else     ph_d <= phi2;
  end

  assign in_alias = (addr >> IDX_W) == (ALIAS_BASE >> IDX_W);
  assign in_io    = (addr >> IDX_W) == (IO_BASE >> IDX_W);
  assign cap      = ph_d & ~phi2 & ~rw & (in_io | in_alias);

  AST_OE_PHASE: assert property (@(posedge clk) disable iff (rst)
    dbus_oe |-> phi2);  // R7

  AST_ALIAS_QUIET: assert property (@(posedge clk) disable iff (rst)
    (in_alias && rw) |-> !dbus_oe);  // R8

  AST_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    !remap_on |-> (pa == PA_W'(addr)));  // R3

  AST_RB_MATCH: assert property (@(posedge clk) disable iff (rst)
    (dbus_oe && remap_on && addr[ADDR_W-1 -: IDX_W] == addr[IDX_W-1:0])
      |-> (dbus_out == pa[PA_W-1 -: DATA_W]));  // R6

  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cap |=> ((addr != $past(addr)) || (remap_on != $past(remap_on))
              || (pa == $past(pa))));  // R9

  AST_OFS_THRU: assert property (@(posedge clk) disable iff (rst)
    pa[OFS_W-1:0] == addr[OFS_W-1:0]);  // R2
endmodule

bind bmap_unit bmap_unit_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
  .IO_BASE(IO_BASE), .ALIAS_BASE(ALIAS_BASE)
) u_chk (.*);

// File: tb/bmap_unit_test.sv
module bmap_unit_test;
  localparam logic [15:0] IOB = 16'hFE00;
  localparam logic [15:0] ALB = 16'h0200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic phi2 = 1'b0;
  logic rw = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic [7:0] dbus_in = 8'h00;
  logic remap_on = 1'b0;
  logic [21:0] pa;
  logic [7:0] dbus_out;
  logic dbus_oe;

  int total = 0;
  int bad = 0;
  logic [7:0] model [4];

  always #5 clk = ~clk;

  bmap_unit #(.IO_BASE(IOB), .ALIAS_BASE(ALB)) uut (
    .clk(clk), .rst(rst), .phi2(phi2), .rw(rw), .addr(addr),
    .dbus_in(dbus_in), .remap_on(remap_on), .pa(pa),
    .dbus_out(dbus_out), .dbus_oe(dbus_oe)
  );

  function automatic logic is_io(input logic [15:0] a);
    return a[15:2] == IOB[15:2];
  endfunction

  function automatic logic is_alias(input logic [15:0] a);
    return a[15:2] == ALB[15:2];
  endfunction

  function automatic logic [21:0] exp_pa(input logic [15:0] a, input logic on);
    if (on) return {model[a[15:14]], a[13:0]};
    return {6'b0, a};
  endfunction

  task automatic chk(input logic ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bus cycle: low phase, high phase, then fall (capture edge)
  task automatic bus(input logic [15:0] a, input logic r, input logic [7:0] d,
                     input string req);
    @(negedge clk); addr = a; rw = r; dbus_in = d; phi2 = 1'b0;
    @(negedge clk);
    chk(dbus_oe == 1'b0, "R7", {31'b0, dbus_oe}, 0);
    phi2 = 1'b1;
    @(negedge clk);
    #1;
    chk(dbus_oe == (r && is_io(a)), req, {31'b0, dbus_oe}, {31'b0, r && is_io(a)});
    if (r && is_io(a))
      chk(dbus_out == model[a[1:0]], "R6", {24'b0, dbus_out}, {24'b0, model[a[1:0]]});
    @(negedge clk); phi2 = 1'b0;
    #1;
    chk(dbus_oe == 1'b0, "R7", {31'b0, dbus_oe}, 0);
    @(negedge clk);
    if (!r && (is_io(a) || is_alias(a))) model[a[1:0]] = d;
    #1;
    chk(pa == exp_pa(a, remap_on), req, {10'b0, pa}, {10'b0, exp_pa(a, remap_on)});
  endtask

  task automatic look(input logic [15:0] a, input logic on, input string req);
    @(negedge clk); addr = a; remap_on = on; rw = 1'b1;
    #1;
    chk(pa == exp_pa(a, on), req, {10'b0, pa}, {10'b0, exp_pa(a, on)});
  endtask

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 8'(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: identity after reset, on both ports
    for (int i = 0; i < 4; i++) begin
      look({2'(i), 14'h0123}, 1'b1, "R1");
      bus(IOB + 16'(i), 1'b1, 8'h00, "R1");
    end
    // R4 writes through the I/O region
    remap_on = 1'b1;
    bus(IOB + 16'd0, 1'b0, 8'hA5, "R4");
    bus(IOB + 16'd3, 1'b0, 8'h3C, "R4");
    look(16'hC456, 1'b1, "R10");
    look(16'h0001, 1'b1, "R2");
    // R5 alias write, R8 alias read
    bus(ALB + 16'd1, 1'b0, 8'h77, "R5");
    look(16'h4000, 1'b1, "R5");
    bus(ALB + 16'd2, 1'b1, 8'h00, "R8");
    // R9: near-miss writes and reads leave the map alone
    bus(IOB + 16'd4, 1'b0, 8'hEE, "R9");
    bus(IOB - 16'd1, 1'b0, 8'hEE, "R9");
    bus(ALB + 16'd4, 1'b0, 8'hEE, "R9");
    bus(IOB + 16'd2, 1'b1, 8'hEE, "R9");
    for (int i = 0; i < 4; i++) bus(IOB + 16'(i), 1'b1, 8'h00, "R9");
    // R3 pass-through
    look(16'hFFFF, 1'b0, "R3");
    look(16'h8ABC, 1'b0, "R3");
    // random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      int sel = $urandom_range(0, 3);
      a = 16'($urandom);
      if (sel == 0) a = IOB + 16'($urandom_range(0, 3));
      else if (sel == 1) a = ALB + 16'($urandom_range(0, 3));
      remap_on = 1'($urandom);
      bus(a, 1'($urandom), 8'($urandom), "R2");
      look(16'($urandom), 1'($urandom), "R10");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule